// File: doc/BRIEF.md
# Per-Queue Deficit Round-Robin Packet Scheduler

This block picks which of several transmit queues may send its next packet. Each queue shows whether it has a packet waiting and how long that packet is. The scheduler answers with a one-hot grant and the granted length. The grant stays up until the downstream data reader accepts it. A global mode input selects how the queues share the link. In plain round-robin the queues take turns one packet at a time, whatever their lengths. In deficit weighted round-robin each queue earns a byte credit (its quantum) per turn and spends it on packets.

Each queue also has three per-queue controls: a strict flag that lets it jump ahead of all weighted queues, a pause control that holds it out of arbitration, and a one-cycle reset command that reloads its credit. Credits start from a programmable initial value and never grow past a programmable ceiling. All per-queue settings are flat vectors on the ports, so a register file outside the block can drive them.

Top module: `dwrr_sched`

## Requirements
- R1: While `rst_n` is low, and in the first clock after it is released, `grant_valid` is 0 and `grant_onehot` is all zero. That first clock loads `cfg_init` into every queue's credit.
- R2: With `sched_mode`=0 (round-robin), the next grant goes to the first eligible non-strict queue at or after the rotating pointer, wrapping from the top index to 0. The pointer then moves to the queue after the winner. Lengths and credits play no part.
- R3: With `sched_mode`=1 (weighted), the pointer visits one queue per idle cycle. On the first look at a queue during a visit, that queue's quantum is added to its credit. The queue is granted, and stays at the pointer, while its credit is at least its head length. The length is taken off when the grant is accepted. Otherwise the pointer moves on.
- R4: Adding a quantum never raises a credit above `cfg_max`. A sum beyond it is clamped to `cfg_max`.
- R5: In weighted mode, when the pointer passes a non-strict, unpaused queue that has no packet waiting, that queue's credit becomes 0. While no non-strict queue is eligible, the pointer and all credits hold.
- R6: A queue with its `cfg_strict` bit set, a packet waiting and no pause wins over every non-strict queue. Among such queues the lowest index wins. A strict grant changes no credit and does not move the pointer.
- R7: A paused queue is never granted and is skipped by the pointer, and its credit is kept.
- R8: A one-cycle pulse on `q_reset[i]` loads `cfg_init` into queue i's credit. If the pointer rests on that queue, the visit is restarted, so a new quantum is added on the next look.
- R9: Once raised, `grant_valid`, `grant_onehot` and `grant_len` hold until an edge where `grant_ready` is 1. `grant_valid` is 0 in the cycle after an accept. `grant_len` equals the winner's `q_len` as sampled at the deciding edge.
- R10: `grant_onehot` bit i stands for queue i and is exactly one-hot while `grant_valid` is 1, and zero otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sched_mode | input | 1 | 0 round-robin, 1 deficit weighted |
| q_valid | input | NQ | Queue i has a head packet |
| q_len | input | NQ*LEN_W | Head packet length of queue i in bits [i*LEN_W +: LEN_W] |
| cfg_quantum | input | NQ*DEF_W | Per-visit credit of queue i in bits [i*DEF_W +: DEF_W] |
| cfg_strict | input | NQ | Queue i bypasses weighting with fixed priority |
| cfg_pause | input | NQ | Queue i held out of arbitration |
| q_reset | input | NQ | One-cycle reload of queue i's credit |
| cfg_init | input | DEF_W | Credit value loaded on reset |
| cfg_max | input | DEF_W | Ceiling of the credit |
| grant_ready | input | 1 | Downstream accepts the grant |
| grant_valid | output | 1 | A grant is offered |
| grant_onehot | output | NQ | Granted queue |
| grant_len | output | LEN_W | Length of the granted packet |

## Verification
The bench pushes on the points where credit accounting goes quietly wrong. If leftover credit survived an empty queue, a later weighted phase would grant that queue first instead of its neighbour. If pause cleared the credit, a resumed queue would lose its turn. If the clamp were missing, a queue with a huge quantum would send two packets where one is expected. If the initial value were ignored, the first winner after reset would change. Strict queues, mode switches with a half-finished visit at the pointer, and grants held for several cycles before acceptance are mixed in. Each wrong design shows up as a grant to an unexpected queue, or as a grant that changes before it is accepted.

// File: rtl/dwrr_pkg.sv
package dwrr_pkg;
  localparam logic MODE_RR   = 1'b0;
  localparam logic MODE_DWRR = 1'b1;

  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/dwrr_prio_pick.sv
module dwrr_prio_pick #(
  parameter int N  = 4,
  localparam int IW = dwrr_pkg::idx_w(N)
) (
  input  logic [N-1:0]  req,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/dwrr_rot_pick.sv
module dwrr_rot_pick #(
  parameter int N  = 4,
  localparam int IW = dwrr_pkg::idx_w(N)
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] base,
  output logic          hit,
  output logic [IW-1:0] idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int k = 0; k < N; k++) begin
      int cand;
      cand = (int'(base) + k) % N;
      if (!hit && req[cand]) begin
        hit = 1'b1;
        idx = IW'(cand);
      end
    end
  end
endmodule

// File: rtl/dwrr_credit.sv
module dwrr_credit #(
  parameter int DEF_W = 20,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [DEF_W-1:0] init_i,
  input  logic             clr_i,
  input  logic             add_i,
  input  logic [DEF_W-1:0] quantum_i,
  input  logic [DEF_W-1:0] cap_i,
  input  logic             sub_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [DEF_W-1:0] credit_o,
  output logic [DEF_W-1:0] credit_sum_o
);
  logic [DEF_W-1:0] credit_q, credit_d;
  logic [DEF_W:0]   sum_wide;
  logic [DEF_W-1:0] len_ext;
  logic             upd_en;

  assign len_ext  = DEF_W'(len_i);
  assign sum_wide = {1'b0, credit_q} + {1'b0, quantum_i};
  assign credit_sum_o = (sum_wide > {1'b0, cap_i}) ? cap_i : sum_wide[DEF_W-1:0];
  assign credit_o = credit_q;
  assign upd_en   = load_i | clr_i | add_i | sub_i;

  always_comb begin
    credit_d = credit_q;
    if (load_i)     credit_d = init_i;
    else if (clr_i) credit_d = '0;
    else if (add_i) credit_d = credit_sum_o;
    else if (sub_i) credit_d = (credit_q >= len_ext) ? (credit_q - len_ext) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      credit_q <= '0;
    else if (upd_en) credit_q <= credit_d;
  end
endmodule

// File: rtl/dwrr_sched.sv
module dwrr_sched #(
  parameter int NQ    = 4,
  parameter int LEN_W = 16,
  parameter int DEF_W = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sched_mode,
  input  logic [NQ-1:0]       q_valid,
  input  logic [NQ*LEN_W-1:0] q_len,
  input  logic [NQ*DEF_W-1:0] cfg_quantum,
  input  logic [NQ-1:0]       cfg_strict,
  input  logic [NQ-1:0]       cfg_pause,
  input  logic [NQ-1:0]       q_reset,
  input  logic [DEF_W-1:0]    cfg_init,
  input  logic [DEF_W-1:0]    cfg_max,
  input  logic                grant_ready,
  output logic                grant_valid,
  output logic [NQ-1:0]       grant_onehot,
  output logic [LEN_W-1:0]    grant_len
);
  localparam int IW = dwrr_pkg::idx_w(NQ);

  logic [IW-1:0]    ptr_q, ptr_d, ptr_inc, rr_inc;
  logic             topped_q, topped_d;
  logic             gv_q, gv_d, gdw_q, gdw_d;
  logic [IW-1:0]    gidx_q, gidx_d;
  logic [LEN_W-1:0] glen_q, glen_d;
  logic             boot_q, boot_d;

  logic [LEN_W-1:0] len_a    [NQ];
  logic [DEF_W-1:0] credit_a [NQ];
  logic [DEF_W-1:0] sum_a    [NQ];
  logic [NQ-1:0]    add_v, clr_v, sub_v;

  logic [NQ-1:0]    elig, strict_req, ns_req;
  logic             strict_hit, rr_hit;
  logic [IW-1:0]    strict_idx, rr_idx;
  logic [DEF_W-1:0] cand;
  logic             fits, accept;

  assign elig       = q_valid & ~cfg_pause & ~q_reset;
  assign strict_req = elig & cfg_strict;
  assign ns_req     = elig & ~cfg_strict;
  assign accept     = gv_q & grant_ready;

  for (genvar i = 0; i < NQ; i++) begin : g_q
    assign len_a[i] = q_len[i*LEN_W +: LEN_W];
    dwrr_credit #(.DEF_W(DEF_W), .LEN_W(LEN_W)) u_credit (
      .clk          (clk),
      .rst_n        (rst_n),
      .load_i       (boot_q | q_reset[i]),
      .init_i       (cfg_init),
      .clr_i        (clr_v[i]),
      .add_i        (add_v[i]),
      .quantum_i    (cfg_quantum[i*DEF_W +: DEF_W]),
      .cap_i        (cfg_max),
      .sub_i        (sub_v[i]),
      .len_i        (glen_q),
      .credit_o     (credit_a[i]),
      .credit_sum_o (sum_a[i])
    );
  end

  dwrr_prio_pick #(.N(NQ)) u_strict (.req(strict_req), .hit(strict_hit), .idx(strict_idx));
  dwrr_rot_pick  #(.N(NQ)) u_rot    (.req(ns_req), .base(ptr_q), .hit(rr_hit), .idx(rr_idx));

  assign ptr_inc = (ptr_q  == IW'(NQ - 1)) ? '0 : ptr_q + 1'b1;
  assign rr_inc  = (rr_idx == IW'(NQ - 1)) ? '0 : rr_idx + 1'b1;
  assign cand    = topped_q ? credit_a[ptr_q] : sum_a[ptr_q];
  assign fits    = cand >= DEF_W'(len_a[ptr_q]);

  always_comb begin
    ptr_d    = ptr_q;
    topped_d = topped_q;
    gv_d     = gv_q;
    gdw_d    = gdw_q;
    gidx_d   = gidx_q;
    glen_d   = glen_q;
    boot_d   = 1'b0;
    add_v    = '0;
    clr_v    = '0;
    sub_v    = '0;
    if (boot_q) begin
      boot_d = 1'b0;
    end else if (gv_q) begin
      if (accept) begin
        gv_d = 1'b0;
        if (gdw_q) sub_v[gidx_q] = 1'b1;
      end
    end else if (strict_hit) begin
      gv_d   = 1'b1;
      gdw_d  = 1'b0;
      gidx_d = strict_idx;
      glen_d = len_a[strict_idx];
    end else if (sched_mode == dwrr_pkg::MODE_RR) begin
      if (rr_hit) begin
        gv_d     = 1'b1;
        gdw_d    = 1'b0;
        gidx_d   = rr_idx;
        glen_d   = len_a[rr_idx];
        ptr_d    = rr_inc;
        topped_d = 1'b0;
      end
    end else if (|ns_req) begin
      if (ns_req[ptr_q]) begin
        if (!topped_q) begin
          add_v[ptr_q] = 1'b1;
          topped_d     = 1'b1;
        end
        if (fits) begin
          gv_d   = 1'b1;
          gdw_d  = 1'b1;
          gidx_d = ptr_q;
          glen_d = len_a[ptr_q];
        end else begin
          ptr_d    = ptr_inc;
          topped_d = 1'b0;
        end
      end else begin
        if (!q_valid[ptr_q] && !cfg_strict[ptr_q] && !cfg_pause[ptr_q] && !q_reset[ptr_q])
          clr_v[ptr_q] = 1'b1;
        ptr_d    = ptr_inc;
        topped_d = 1'b0;
      end
    end
    if (q_reset[ptr_q]) topped_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q    <= '0;
      topped_q <= 1'b0;
      gv_q     <= 1'b0;
      gdw_q    <= 1'b0;
      gidx_q   <= '0;
      glen_q   <= '0;
      boot_q   <= 1'b1;
    end else begin
      ptr_q    <= ptr_d;
      topped_q <= topped_d;
      gv_q     <= gv_d;
      gdw_q    <= gdw_d;
      gidx_q   <= gidx_d;
      glen_q   <= glen_d;
      boot_q   <= boot_d;
    end
  end

  assign grant_valid = gv_q;
  assign grant_len   = glen_q;
  always_comb begin
    for (int i = 0; i < NQ; i++) grant_onehot[i] = gv_q && (gidx_q == IW'(i));
  end
endmodule

// File: rtl/dwrr_sched_chk.sv
module dwrr_sched_chk #(
  parameter int NQ    = 4,
  parameter int LEN_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NQ-1:0]       q_valid,
  input logic [NQ*LEN_W-1:0] q_len,
  input logic [NQ-1:0]       cfg_strict,
  input logic [NQ-1:0]       cfg_pause,
  input logic [NQ-1:0]       q_reset,
  input logic                grant_ready,
  input logic                grant_valid,
  input logic [NQ-1:0]       grant_onehot,
  input logic [LEN_W-1:0]    grant_len
);
  logic [NQ*LEN_W-1:0] len_prev;
  logic [LEN_W-1:0]    exp_len;
  logic [NQ-1:0]       strict_elig;

  always_ff @(posedge clk) len_prev <= q_len;

  assign strict_elig = q_valid & ~cfg_pause & ~q_reset & cfg_strict;

  always_comb begin
    exp_len = '0;
    for (int i = 0; i < NQ; i++)
      if (grant_onehot[i]) exp_len = len_prev[i*LEN_W +: LEN_W];
  end

  p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> $onehot(grant_onehot));
  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !grant_valid |-> (grant_onehot == '0));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !grant_ready) |=> (grant_valid && $stable(grant_onehot) && $stable(grant_len)));
  p_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && grant_ready) |=> !grant_valid);
  p_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_valid) |-> (grant_len == exp_len));
  p_strict_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(grant_valid) && ((grant_onehot & $past(cfg_strict)) == '0)) |-> ($past(strict_elig) == '0));
  p_no_paused_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_valid) |-> ((grant_onehot & $past(cfg_pause | ~q_valid)) == '0));
endmodule

bind dwrr_sched dwrr_sched_chk #(.NQ(NQ), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .q_valid(q_valid), .q_len(q_len),
  .cfg_strict(cfg_strict), .cfg_pause(cfg_pause), .q_reset(q_reset),
  .grant_ready(grant_ready), .grant_valid(grant_valid),
  .grant_onehot(grant_onehot), .grant_len(grant_len)
);

// File: tb/sim_dwrr_sched.sv
module sim_dwrr_sched;
  localparam int NQ = 4;
  localparam int LW = 16;
  localparam int DW = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic            mode;
  logic [NQ-1:0]   vmask, smask, pmask, rmask;
  logic [NQ*LW-1:0] qlen_bus;
  logic [NQ*DW-1:0] quant_bus;
  logic [DW-1:0]   init_v, max_v;
  logic            ready;
  logic            gvalid;
  logic [NQ-1:0]   gonehot;
  logic [LW-1:0]   glen;

  int quant [NQ];
  int qlen  [NQ];
  int m_def [NQ];
  int m_ptr, m_top;
  int errors = 0;
  int checks = 0;

  for (genvar i = 0; i < NQ; i++) begin : g_bus
    assign qlen_bus[i*LW +: LW]  = LW'(qlen[i]);
    assign quant_bus[i*DW +: DW] = DW'(quant[i]);
  end

  dwrr_sched #(.NQ(NQ), .LEN_W(LW), .DEF_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .sched_mode(mode), .q_valid(vmask),
    .q_len(qlen_bus), .cfg_quantum(quant_bus), .cfg_strict(smask),
    .cfg_pause(pmask), .q_reset(rmask), .cfg_init(init_v), .cfg_max(max_v),
    .grant_ready(ready), .grant_valid(gvalid), .grant_onehot(gonehot),
    .grant_len(glen)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_next();
    bit any;
    for (int i = 0; i < NQ; i++)
      if (vmask[i] && !pmask[i] && smask[i]) return i;
    if (mode == 1'b0) begin
      for (int k = 0; k < NQ; k++) begin
        int i;
        i = (m_ptr + k) % NQ;
        if (vmask[i] && !pmask[i] && !smask[i]) begin
          m_ptr = (i + 1) % NQ;
          m_top = 0;
          return i;
        end
      end
      return -1;
    end
    any = 0;
    for (int i = 0; i < NQ; i++) any |= vmask[i] && !pmask[i] && !smask[i];
    if (!any) return -1;
    for (int it = 0; it < 100000; it++) begin
      int q;
      q = m_ptr;
      if (vmask[q] && !pmask[q] && !smask[q]) begin
        if (m_top == 0) begin
          m_def[q] = m_def[q] + quant[q];
          if (m_def[q] > int'(max_v)) m_def[q] = int'(max_v);
          m_top = 1;
        end
        if (m_def[q] >= qlen[q]) begin
          m_def[q] -= qlen[q];
          return q;
        end
      end else if (!vmask[q] && !smask[q] && !pmask[q]) begin
        m_def[q] = 0;
      end
      m_ptr = (q + 1) % NQ;
      m_top = 0;
    end
    return -1;
  endfunction

  task automatic pulse_reset(input logic [NQ-1:0] mask);
    @(negedge clk);
    rmask = mask;
    @(negedge clk);
    rmask = '0;
    for (int i = 0; i < NQ; i++) if (mask[i]) m_def[i] = int'(init_v);
    if (mask[m_ptr]) m_top = 0;
  endtask

  task automatic run_phase(input string req, input logic [NQ-1:0] v, input int n);
    @(negedge clk);
    vmask = v;
    for (int g = 0; g < n; g++) begin
      int exp_q, waitc, hold;
      exp_q = model_next();
      if (exp_q < 0) break;
      waitc = 0;
      while (!gvalid && waitc < 3000) begin
        @(negedge clk);
        waitc++;
      end
      chk(gvalid == 1'b1, req, int'(gvalid), 1);
      chk(gonehot == NQ'(1 << exp_q), req, int'(gonehot), 1 << exp_q);
      chk(glen == LW'(qlen[exp_q]), "R9", int'(glen), qlen[exp_q]);
      hold = $urandom_range(0, 2);
      for (int h = 0; h < hold; h++) begin
        @(negedge clk);
        chk(gvalid && gonehot == NQ'(1 << exp_q), "R9", int'(gonehot), 1 << exp_q);
      end
      ready = 1'b1;
      @(negedge clk);
      ready = 1'b0;
      if (g == n - 1) vmask = '0;
      chk(gvalid == 1'b0 && gonehot == '0, "R10", int'(gonehot), 0);
    end
    vmask = '0;
    repeat (2) @(negedge clk);
  endtask

  task automatic set_q(input int i, input int qu, input int ln);
    quant[i] = qu;
    qlen[i]  = ln;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    mode = 1'b1; vmask = '0; smask = '0; pmask = '0; rmask = '0; ready = 1'b0;
    init_v = DW'(600); max_v = DW'(4000);
    for (int i = 0; i < NQ; i++) set_q(i, 500, 500);
    set_q(0, 100, 500);
    #12;
    chk(gvalid == 1'b0 && gonehot == '0, "R1", int'(gvalid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(gvalid == 1'b0 && gonehot == '0, "R1", int'(gonehot), 0);
    for (int i = 0; i < NQ; i++) m_def[i] = 600;
    m_ptr = 0; m_top = 0;
    // initial credit 600 lets queue 0 win its first visit
    run_phase("R1", 4'b0011, 4);

    // cap: huge quantum clamped, one packet per visit
    max_v = DW'(700);
    set_q(0, 3000, 500); set_q(1, 3000, 500);
    pulse_reset(4'b1111);
    run_phase("R4", 4'b0011, 6);

    // leftover credit cleared when an empty queue is passed
    max_v = DW'(4000); init_v = '0;
    set_q(0, 700, 500); set_q(1, 700, 500);
    pulse_reset(4'b1111);
    run_phase("R3", 4'b0011, 3);
    run_phase("R5", 4'b0010, 1);
    set_q(0, 300, 500); set_q(1, 300, 500);
    run_phase("R5", 4'b0011, 3);

    // pause keeps credit
    set_q(0, 700, 500); set_q(1, 700, 500);
    pulse_reset(4'b1111);
    run_phase("R3", 4'b0011, 3);
    pmask = 4'b0001;
    run_phase("R7", 4'b0011, 1);
    pmask = '0;
    set_q(0, 300, 500); set_q(1, 300, 500);
    run_phase("R7", 4'b0011, 3);

    // queue reset reloads initial credit
    init_v = DW'(450);
    pulse_reset(4'b0001);
    run_phase("R8", 4'b0011, 4);

    // strict priority, lowest index among strict
    smask = 4'b0100;
    run_phase("R6", 4'b1111, 3);
    smask = 4'b1010;
    run_phase("R6", 4'b1111, 3);
    pmask = 4'b0010;
    run_phase("R6", 4'b1111, 2);
    smask = '0; pmask = '0;

    // round-robin ignores lengths and credits
    mode = 1'b0;
    set_q(2, 10, 1500);
    run_phase("R2", 4'b1101, 6);
    mode = 1'b1;
    run_phase("R3", 4'b1111, 5);

    for (int p = 0; p < 40; p++) begin
      logic [NQ-1:0] v;
      mode = ($urandom_range(0, 9) < 7);
      for (int i = 0; i < NQ; i++) begin
        set_q(i, $urandom_range(200, 1700),
              ($urandom_range(0, 9) == 0) ? 0 : $urandom_range(1, 1500));
        smask[i] = ($urandom_range(0, 7) == 0);
        pmask[i] = ($urandom_range(0, 5) == 0);
        v[i]     = ($urandom_range(0, 4) != 0);
      end
      if ((v & ~pmask) == '0) begin v[0] = 1'b1; pmask[0] = 1'b0; end
      init_v = DW'($urandom_range(0, 2000));
      max_v  = DW'(1500 + $urandom_range(0, 3000));
      if ($urandom_range(0, 1) == 1) pulse_reset(NQ'($urandom_range(1, 15)));
      run_phase(mode ? "R3" : "R2", v, $urandom_range(3, 8));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule